// File: doc/BRIEF.md
# Frame-Synced Serial Receive Bridge

This block takes a bit-serial sample stream from an external converter or line front end and delivers it to a host in 32-bit reads. Serial data is sampled on an externally supplied serial clock. A frame pulse from the same device marks the first bit of each 16-bit sample, and the sample is assembled most significant bit first. Each finished sample is written into a 32-entry dual-clock FIFO. The FIFO carries the data from the serial clock domain into the host clock domain, with Gray-coded pointers crossing between the two.

The host sees a 32-bit read port that always shows the two oldest samples. The older sample sits in the low half and the newer one in the high half. A read strobe consumes both samples at once. The block also gives the host the current fill level, a flag that a full pair is waiting, and an interrupt request that rises once the fill level reaches a threshold the host programs. When a sample finishes while the FIFO is full, that sample is thrown away and a sticky overrun flag is raised. The host clears the flag with a write-one-to-clear strobe. The block does only register-style transfers and never masters a bus.

Top module: `frame_rx_bridge`

## Requirements
- R1: Once reset is released, level_o reads 0, and pair_avail_o, ovr_o and irq_o all read 0.
- R2: ser_dat_i is sampled on the rising edge of ser_clk_i. The bit sampled while ser_fs_i is high is bit 15 of a new sample. The next 15 rising edges supply bits 14 down to 0, and the sample is written to the FIFO on the edge that samples bit 0.
- R3: When ser_fs_i is high while a sample is only partly received, the partial sample is discarded and a new sample starts with the current bit.
- R4: Bits sampled while no sample is in progress, meaning after bit 0 and before the next frame pulse, are ignored and add nothing to the FIFO.
- R5: level_o gives the number of unread samples in the host domain, from 0 up to 32.
- R6: While level_o is 2 or more, pair_avail_o is 1 and rd_data_o holds the oldest sample in bits 15:0 and the next-oldest in bits 31:16. A one-cycle rd_en_i pulse removes both samples.
- R7: A rd_en_i pulse while level_o is below 2 has no effect: level_o and the stored samples stay unchanged.
- R8: A sample that finishes while the FIFO holds 32 entries is discarded, the 32 stored samples stay intact, and ovr_o goes to 1 and stays there.
- R9: A one-cycle ovr_clr_i pulse clears ovr_o when no new overrun arrives in the same cycle.
- R10: irq_o is 1 exactly when thresh_i is nonzero and level_o is at least thresh_i. A thresh_i of 0 holds irq_o low.
- R11: Samples reach the host in the order they were received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| ser_clk_i | input | 1 | External serial bit clock |
| ser_fs_i | input | 1 | Frame pulse; high during the first bit of a sample |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| rd_en_i | input | 1 | Host read strobe; consumes two samples |
| rd_data_o | output | 32 | Oldest sample in [15:0], next-oldest in [31:16] |
| pair_avail_o | output | 1 | At least two samples are waiting |
| level_o | output | 6 | Unread sample count, 0 to 32 |
| thresh_i | input | 6 | Fill level that raises irq_o; 0 disables it |
| ovr_clr_i | input | 1 | Write-one-to-clear strobe for ovr_o |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The bench sends a frame pulse in the middle of a sample. A deframer that kept the partial bits or kept counting from the old position would return a wrong sample or an extra one. It toggles the data line with no frame pulse, which a design that free-runs its bit counter would turn into phantom samples. It strobes a read with only one sample stored, which would underflow the pointer and corrupt the pairing of later reads. It fills the FIFO past 32 entries, then checks that the overrun flag is set and that the first 32 samples come back in order with none overwritten, which catches a design that wraps the write pointer or pushes while full. Word packing and the irq threshold, including the disabled value, are checked against the computed fill level.

// File: rtl/frb_pkg.sv
package frb_pkg;
  localparam int unsigned FRB_WORD_W      = 16;
  localparam int unsigned FRB_DEPTH       = 32;
  localparam int unsigned FRB_SYNC_STAGES = 2;
endpackage

// File: rtl/frb_sync.sv
module frb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = frb_pkg::FRB_SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/frb_deframer.sv
module frb_deframer #(
  parameter int unsigned WORD_W = frb_pkg::FRB_WORD_W,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              ser_clk_i,
  input  logic              rst_ni,
  input  logic              fs_i,
  input  logic              dat_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              act_q;
  logic              last_bit;

  assign last_bit = act_q && (cnt_q == CNT_W'(WORD_W-1));
  // a frame pulse on the final bit wins: the partial word is dropped
  assign push_o   = last_bit && !fs_i;
  assign word_o   = {sr_q[WORD_W-2:0], dat_i};

  always_ff @(posedge ser_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (fs_i) begin
      sr_q  <= {{(WORD_W-1){1'b0}}, dat_i};
      cnt_q <= CNT_W'(1);
      act_q <= 1'b1;
    end else if (act_q) begin
      sr_q <= {sr_q[WORD_W-2:0], dat_i};
      if (last_bit) begin
        cnt_q <= '0;
        act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  a_r3_sync_restart: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
    fs_i |=> (act_q && cnt_q == CNT_W'(1)));
  a_r4_idle_after_word: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
    push_o |=> !act_q);
endmodule

// File: rtl/frb_cdc_fifo.sv
module frb_cdc_fifo #(
  parameter int unsigned WORD_W = frb_pkg::FRB_WORD_W,
  parameter int unsigned DEPTH  = frb_pkg::FRB_DEPTH,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1
) (
  input  logic                wclk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic                drop_o,
  input  logic                rclk_i,
  input  logic                pop_i,
  output logic [2*WORD_W-1:0] rdata_o,
  output logic [PW-1:0]       level_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  // write side: entry pointer, Gray copy for the host domain
  logic [PW-1:0] wbin_q, wgray_q, wnext;
  logic [AW-1:0] rgray_ws, rpair_ws;
  logic [PW-1:0] rent_ws;
  logic          full;

  // read side: pointer counts pairs so one Gray bit moves per pop
  logic [AW-1:0] rpair_q, rpair_gray_q, rpair_next;
  logic [PW-1:0] wgray_rs, wbin_rs, rent;
  logic [AW-1:0] raddr_lo, raddr_hi;
  logic          pop_ok;

  frb_sync #(.W(AW)) i_rptr_sync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rpair_gray_q), .q_o(rgray_ws));
  frb_sync #(.W(PW)) i_wptr_sync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_rs));

  always_comb begin
    rpair_ws[AW-1] = rgray_ws[AW-1];
    for (int i = int'(AW) - 2; i >= 0; i--) rpair_ws[i] = rpair_ws[i+1] ^ rgray_ws[i];
  end

  assign rent_ws = {rpair_ws, 1'b0};
  assign full    = (wbin_q - rent_ws) == PW'(DEPTH);
  assign drop_o  = push_i && full;
  assign wnext   = wbin_q + PW'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push_i && !full) begin
      wbin_q  <= wnext;
      wgray_q <= wnext ^ (wnext >> 1);
    end
  end

  always_ff @(posedge wclk_i) begin
    if (push_i && !full) mem_q[wbin_q[AW-1:0]] <= wdata_i;
  end

  always_comb begin
    wbin_rs[PW-1] = wgray_rs[PW-1];
    for (int i = int'(PW) - 2; i >= 0; i--) wbin_rs[i] = wbin_rs[i+1] ^ wgray_rs[i];
  end

  assign rent       = {rpair_q, 1'b0};
  assign level_o    = wbin_rs - rent;
  assign pop_ok     = pop_i && (level_o >= PW'(2));
  assign rpair_next = rpair_q + AW'(1);
  assign raddr_lo   = {rpair_q[AW-2:0], 1'b0};
  assign raddr_hi   = {rpair_q[AW-2:0], 1'b1};
  assign rdata_o    = {mem_q[raddr_hi], mem_q[raddr_lo]};

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rpair_q      <= '0;
      rpair_gray_q <= '0;
    end else if (pop_ok) begin
      rpair_q      <= rpair_next;
      rpair_gray_q <= rpair_next ^ (rpair_next >> 1);
    end
  end

  a_r5_level_bound: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    level_o <= PW'(DEPTH));
  a_r7_no_short_pop: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (pop_i && level_o < PW'(2)) |=> $stable(rpair_q));
  a_r8_full_holds_ptr: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (push_i && full) |=> $stable(wbin_q));
endmodule

// File: rtl/frame_rx_bridge.sv
module frame_rx_bridge #(
  parameter int unsigned WORD_W = frb_pkg::FRB_WORD_W,
  parameter int unsigned DEPTH  = frb_pkg::FRB_DEPTH,
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ser_clk_i,
  input  logic                ser_fs_i,
  input  logic                ser_dat_i,
  input  logic                rd_en_i,
  output logic [2*WORD_W-1:0] rd_data_o,
  output logic                pair_avail_o,
  output logic [LVL_W-1:0]    level_o,
  input  logic [LVL_W-1:0]    thresh_i,
  input  logic                ovr_clr_i,
  output logic                ovr_o,
  output logic                irq_o
);
  logic              push;
  logic [WORD_W-1:0] word;
  logic              drop;
  logic              drop_tgl_q;
  logic              drop_tgl_s, drop_tgl_d_q;
  logic              ovr_set;
  logic              ovr_q;

  frb_deframer #(.WORD_W(WORD_W)) i_deframer (
    .ser_clk_i(ser_clk_i), .rst_ni(rst_ni), .fs_i(ser_fs_i), .dat_i(ser_dat_i),
    .push_o(push), .word_o(word));

  frb_cdc_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_fifo (
    .wclk_i(ser_clk_i), .rst_ni(rst_ni), .push_i(push), .wdata_i(word),
    .drop_o(drop), .rclk_i(clk_i), .pop_i(rd_en_i), .rdata_o(rd_data_o),
    .level_o(level_o));

  // drop events cross as a toggle, turned back into a pulse on the host side
  always_ff @(posedge ser_clk_i or negedge rst_ni) begin
    if (!rst_ni)   drop_tgl_q <= 1'b0;
    else if (drop) drop_tgl_q <= ~drop_tgl_q;
  end

  frb_sync #(.W(1)) i_drop_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(drop_tgl_q), .q_o(drop_tgl_s));

  assign ovr_set = drop_tgl_s ^ drop_tgl_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drop_tgl_d_q <= 1'b0;
      ovr_q        <= 1'b0;
    end else begin
      drop_tgl_d_q <= drop_tgl_s;
      if (ovr_set)        ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign ovr_o        = ovr_q;
  assign pair_avail_o = level_o >= LVL_W'(2);
  assign irq_o        = (thresh_i != '0) && (level_o >= thresh_i);

  a_r9_clear_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_clr_i && !ovr_set) |=> !ovr_o);
  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);
endmodule

// File: tb/test_frame_rx_bridge.sv
module test_frame_rx_bridge;
  logic        clk_i = 1'b0;
  logic        ser_clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ser_fs = 1'b0;
  logic        ser_dat = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  thresh = '0;
  logic        ovr_clr = 1'b0;
  logic [31:0] rd_data;
  logic        pair_avail;
  logic [5:0]  level;
  logic        ovr, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;
  always #40 ser_clk = ~ser_clk;

  frame_rx_bridge i_frame_rx_bridge (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_clk_i(ser_clk), .ser_fs_i(ser_fs),
    .ser_dat_i(ser_dat), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .pair_avail_o(pair_avail), .level_o(level), .thresh_i(thresh),
    .ovr_clr_i(ovr_clr), .ovr_o(ovr), .irq_o(irq));

  // {older, newer, expected read}
  localparam logic [63:0] VEC [4] = '{
    {16'h8001, 16'h1234, 32'h1234_8001},
    {16'hFFFF, 16'h0000, 32'h0000_FFFF},
    {16'hA5A5, 16'h5A5A, 32'h5A5A_A5A5},
    {16'h0001, 16'h8000, 32'h8000_0001}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      @(negedge ser_clk);
      ser_fs  = (i == 15);
      ser_dat = w[i];
    end
  endtask

  task automatic settle();
    @(negedge ser_clk);
    ser_fs  = 1'b0;
    ser_dat = 1'b0;
    repeat (3) @(posedge ser_clk);
    repeat (8) @(negedge clk_i);
  endtask

  task automatic pop();
    @(negedge clk_i);
    rd_en = 1'b1;
    @(negedge clk_i);
    rd_en = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 reset state
    check(level == 0, "R1 level", 32'(level), 0);
    check(!pair_avail && !ovr && !irq, "R1 flags", {29'b0, pair_avail, ovr, irq}, 0);

    // R2 R6 R11 vector table
    foreach (VEC[v]) begin
      send_word(VEC[v][63:48]);
      send_word(VEC[v][47:32]);
      settle();
      check(level == 2 && pair_avail, "R6 pair ready", 32'(level), 2);
      check(rd_data == VEC[v][31:0], "R2 R11 packing", rd_data, VEC[v][31:0]);
      pop();
      check(level == 0, "R6 pop two", 32'(level), 0);
    end

    // R4 bits with no frame pulse are ignored
    for (int i = 0; i < 20; i++) begin
      @(negedge ser_clk);
      ser_fs  = 1'b0;
      ser_dat = i[0];
    end
    settle();
    check(level == 0, "R4 idle bits", 32'(level), 0);

    // R3 frame pulse mid-word restarts
    for (int i = 15; i >= 9; i--) begin
      @(negedge ser_clk);
      ser_fs  = (i == 15);
      ser_dat = 16'hDEAD >> i;
    end
    send_word(16'h1357);
    send_word(16'h2468);
    settle();
    check(level == 2, "R3 restart count", 32'(level), 2);
    check(rd_data == 32'h2468_1357, "R3 restart data", rd_data, 32'h2468_1357);
    pop();

    // R7 read with one entry is ignored
    send_word(16'hC0DE);
    settle();
    check(level == 1 && !pair_avail, "R7 one entry", 32'(level), 1);
    pop();
    repeat (2) @(negedge clk_i);
    check(level == 1, "R7 short pop ignored", 32'(level), 1);
    send_word(16'h0BEE);
    settle();
    check(rd_data == 32'h0BEE_C0DE, "R7 data kept", rd_data, 32'h0BEE_C0DE);
    pop();
    check(level == 0, "R7 drained", 32'(level), 0);

    // R10 interrupt threshold
    thresh = 6'd3;
    send_word(16'h0101);
    send_word(16'h0202);
    settle();
    check(!irq, "R10 below threshold", {31'b0, irq}, 0);
    send_word(16'h0303);
    settle();
    check(irq, "R10 at threshold", {31'b0, irq}, 1);
    @(negedge clk_i);
    thresh = 6'd0;
    @(negedge clk_i);
    check(!irq, "R10 disabled", {31'b0, irq}, 0);
    send_word(16'h0404);
    settle();
    check(rd_data == 32'h0202_0101, "R11 order", rd_data, 32'h0202_0101);
    pop();
    pop();
    check(level == 0, "R10 drained", 32'(level), 0);

    // R5 R8 overrun: 34 words into 32 slots
    for (int k = 0; k < 34; k++) send_word(16'(16'h4000 + k));
    settle();
    check(level == 32, "R5 full level", 32'(level), 32);
    check(ovr, "R8 overrun set", {31'b0, ovr}, 1);
    for (int k = 0; k < 16; k++) begin
      check(rd_data == {16'(16'h4001 + 2 * k), 16'(16'h4000 + 2 * k)},
            "R8 contents intact", rd_data,
            {16'(16'h4001 + 2 * k), 16'(16'h4000 + 2 * k)});
      pop();
    end
    check(level == 0, "R8 drained", 32'(level), 0);
    check(ovr, "R8 sticky", {31'b0, ovr}, 1);

    // R9 clear
    @(negedge clk_i);
    ovr_clr = 1'b1;
    @(negedge clk_i);
    ovr_clr = 1'b0;
    check(!ovr, "R9 cleared", {31'b0, ovr}, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule